// File: doc/BRIEF.md
# Hidden and Forced DRAM Refresh Controller

This block handles the refresh duty of a DRAM controller. A slow refresh-period clock marks the intervals in which each row must be refreshed. While that clock is high, the block waits for a bus cycle aimed at some other device: chip select is deasserted and the access strobe goes low. It uses that cycle to refresh one row. The row counter drives the refresh address and an all-banks RAS enable is raised for as long as the access strobe stays low.

Only one such stolen refresh is taken per refresh period. If the period's high phase ends with no refresh done, the block raises a refresh request. The system answers with an active-low acknowledge, and the block runs a forced refresh timed by its own clock (the generator clock): a fixed RAS-active phase, then a precharge phase. It then advances the row counter and drops the request. The refresh-period clock and chip select are asynchronous and pass through two-flop synchronisers. The access strobe and the acknowledge are sampled directly on the generator clock.

Top module: `refresh_steal`

## Requirements
- R1: After reset, rf_addr is 0 and ras_all and rf_req are 0.
- R2: A hidden refresh starts when all of the following hold: the synchronised period clock is high, the synchronised cs_n is high, acc_n is sampled low, and no refresh has yet been done in this period. ras_all is then 1 from the next cycle and rf_addr shows the current row.
- R3: A hidden refresh ends on the first edge that samples acc_n high. ras_all goes to 0 and rf_addr advances by one on that same edge.
- R4: At most one hidden refresh is taken per period. An access with cs_n low (selected) never starts a refresh.
- R5: rf_req goes to 1 a few cycles after the period clock falls, but only if no refresh was done during that period. Otherwise it stays 0.
- R6: While rf_req is 1, an edge that samples ack_n low starts a forced refresh. ras_all is 1 for exactly 4 cycles and then 0 for 2 precharge cycles with rf_req still 1. After that, rf_req returns to 0 and rf_addr advances by one.
- R7: While the period clock is low, an access with cs_n high does not start a refresh.
- R8: The row counter is 9 bits wide and wraps from 511 to 0.
- R9: ack_n has no effect while rf_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator clock |
| rst | input | 1 | Synchronous active-high reset |
| period_clk | input | 1 | Refresh-period clock, asynchronous |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| acc_n | input | 1 | Access strobe, active low, synchronous to clk |
| ack_n | input | 1 | Forced-refresh acknowledge, active low |
| rf_addr | output | 9 | Refresh row address |
| ras_all | output | 1 | All-banks RAS enable (1 = RAS asserted) |
| rf_req | output | 1 | Forced-refresh request |

## Verification
The assertions assume that the system lets a forced refresh finish before the next rising edge of the period clock. They also assume that the row counter moves only through completed refreshes. The stimulus keeps to both assumptions. Each period is a full high phase, then a low phase that is long enough for any request to be acknowledged and served. Chip select is changed at least three cycles before any access strobe, so the synchroniser has settled before the strobe is sampled. Random choices cover the type of access in each period, strobe lengths, gaps, and stray acknowledge pulses. The run spans enough periods to carry the counter through its wrap.

// File: rtl/refresh_steal.sv
module refresh_steal #(
  parameter int ROW_W   = 9,
  parameter int RAS_CYC = 4,
  parameter int PRE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_clk,
  input  logic             cs_n,
  input  logic             acc_n,
  input  logic             ack_n,
  output logic [ROW_W-1:0] rf_addr,
  output logic             ras_all,
  output logic             rf_req
);
  localparam int MAXC = (RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {IDLE, HID, FRAS, FPRE} st_t;

  st_t           st;
  logic [2:0]    per_sy;
  logic [1:0]    cs_sy;
  logic [CW-1:0] tcnt;
  logic          done;

  wire per_s    = per_sy[1];
  wire per_rise = per_sy[1] & ~per_sy[2];
  wire per_fall = ~per_sy[1] & per_sy[2];
  wire hid_go   = (st == IDLE) && per_s && cs_sy[1] && !acc_n && !done;
  wire hid_end  = (st == HID) && acc_n;
  wire frc_go   = (st == IDLE) && rf_req && !ack_n;
  wire ras_last = (st == FRAS) && (tcnt == CW'(RAS_CYC - 1));
  wire frc_end  = (st == FPRE) && (tcnt == CW'(PRE_CYC - 1));

  assign ras_all = (st == HID) || (st == FRAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_sy <= '0;
      cs_sy  <= 2'b11;
    end else begin
      per_sy <= {per_sy[1:0], period_clk};
      cs_sy  <= {cs_sy[0], cs_n};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= IDLE;
      tcnt    <= '0;
      done    <= 1'b0;
      rf_req  <= 1'b0;
      rf_addr <= '0;
    end else begin
      case (st)
        IDLE: begin
          tcnt <= '0;
          if (frc_go)      st <= FRAS;
          else if (hid_go) st <= HID;
        end
        HID: if (hid_end) st <= IDLE;
        FRAS: begin
          tcnt <= ras_last ? '0 : tcnt + 1'b1;
          if (ras_last) st <= FPRE;
        end
        FPRE: begin
          tcnt <= frc_end ? '0 : tcnt + 1'b1;
          if (frc_end) st <= IDLE;
        end
        default: st <= IDLE;
      endcase

      if (hid_end || frc_end) rf_addr <= rf_addr + 1'b1;

      if (hid_go || frc_end) done <= 1'b1;
      else if (per_rise)     done <= 1'b0;

      if (frc_end)                rf_req <= 1'b0;
      else if (per_fall && !done) rf_req <= 1'b1;
    end
  end
endmodule

module refresh_steal_chk #(
  parameter int ROW_W   = 9,
  parameter int RAS_CYC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ack_n,
  input logic [ROW_W-1:0] rf_addr,
  input logic             ras_all,
  input logic             rf_req
);
  logic [7:0] run;
  always_ff @(posedge clk) begin
    if (rst)          run <= '0;
    else if (!ras_all) run <= '0;
    else if (run != 8'hff) run <= run + 1'b1;
  end

  a_r8_step_by_one: assert property (@(posedge clk) disable iff (rst)
    !$stable(rf_addr) |-> rf_addr == ROW_W'($past(rf_addr) + 1'b1));

  a_r6_req_drop_advances: assert property (@(posedge clk) disable iff (rst)
    $fell(rf_req) |-> rf_addr == ROW_W'($past(rf_addr) + 1'b1));

  a_r6_ras_width: assert property (@(posedge clk) disable iff (rst)
    (rf_req && ras_all) |-> run < 8'(RAS_CYC));

  a_r5_req_rise_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(rf_req) |-> !ras_all);

  a_r3_ras_fall_advances: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_all) && !rf_req) |-> !$stable(rf_addr));
endmodule

bind refresh_steal refresh_steal_chk #(.ROW_W(ROW_W), .RAS_CYC(RAS_CYC)) u_chk (
  .clk(clk), .rst(rst), .ack_n(ack_n), .rf_addr(rf_addr),
  .ras_all(ras_all), .rf_req(rf_req)
);

// File: tb/test_refresh_steal.sv
module test_refresh_steal;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       period_clk = 1'b0, cs_n = 1'b1, acc_n = 1'b1, ack_n = 1'b1;
  logic [8:0] rf_addr;
  logic       ras_all, rf_req;
  int         total = 0, bad = 0;
  logic [8:0] exp_row = 9'd0;
  logic       wrapped = 1'b0;

  always #2.5 clk = ~clk;

  refresh_steal i_refresh_steal (
    .clk(clk), .rst(rst), .period_clk(period_clk), .cs_n(cs_n),
    .acc_n(acc_n), .ack_n(ack_n), .rf_addr(rf_addr),
    .ras_all(ras_all), .rf_req(rf_req)
  );

  function automatic logic [8:0] next_row(input logic [8:0] r);
    return 9'((int'(r) + 1) % 512);
  endfunction

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic hidden_try(input logic sel_n, input int hold, input logic expect_ras, input string req);
    cs_n = sel_n;
    step(3);
    acc_n = 1'b0;
    step(1);
    chk(req, ras_all, expect_ras);
    if (expect_ras) chk({req, " addr"}, rf_addr, exp_row);
    step(hold);
    chk(req, ras_all, expect_ras);
    acc_n = 1'b1;
    step(1);
    chk(req, ras_all, 0);
    if (expect_ras) begin
      exp_row = next_row(exp_row);
      chk("R3 advance", rf_addr, exp_row);
      if (exp_row == 9'd0) begin
        wrapped = 1'b1;
        chk("R8 wrap", rf_addr, 0);
      end
    end
    step(1 + $urandom_range(0, 2));
  endtask

  task automatic forced(input string req);
    int hi = 0, pre = 0, guard = 0;
    ack_n = 1'b0;
    step(1);
    while (rf_req && guard < 30) begin
      if (ras_all) hi++;
      else if (hi > 0) pre++;
      guard++;
      step(1);
    end
    ack_n = 1'b1;
    chk({req, " ras cycles"}, hi, 4);
    chk({req, " precharge"}, pre, 2);
    chk({req, " req drop"}, rf_req, 0);
    exp_row = next_row(exp_row);
    chk({req, " addr"}, rf_addr, exp_row);
    if (exp_row == 9'd0) begin
      wrapped = 1'b1;
      chk("R8 wrap", rf_addr, 0);
    end
  endtask

  task automatic period(input int mode);
    period_clk = 1'b1;
    step(4);
    if (mode == 0) begin
      hidden_try(1'b1, $urandom_range(0, 3), 1'b1, "R2 hidden");
      hidden_try(1'b1, 1, 1'b0, "R4 second");
    end else if (mode == 1) begin
      hidden_try(1'b0, $urandom_range(0, 3), 1'b0, "R4 selected");
    end else begin
      step($urandom_range(2, 6));
    end
    period_clk = 1'b0;
    step(6);
    chk("R5 request", rf_req, mode != 0);
    if (mode != 0) begin
      forced("R6 forced");
      hidden_try(1'b1, 1, 1'b0, "R7 window closed");
    end else if ($urandom_range(0, 1) == 1) begin
      ack_n = 1'b0;
      step(3);
      chk("R9 ack ignored ras", ras_all, 0);
      chk("R9 ack ignored addr", rf_addr, exp_row);
      ack_n = 1'b1;
      step(1);
    end
    step($urandom_range(1, 4));
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      begin
        step(4);
        chk("R1 addr", rf_addr, 0);
        chk("R1 ras", ras_all, 0);
        chk("R1 req", rf_req, 0);
        rst = 1'b0;
        step(2);
        period(0);
        period(1);
        period(2);
        for (int k = 0; k < 530; k++) period(int'($urandom_range(0, 2)));
        chk("R8 wrap seen", wrapped, 1);
      end
      begin
        step(150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule